// File: doc/BRIEF.md
# Mode-Banked Serial Port Register File

This block is the host-facing register file of a 16550-style serial port. The register map is banked. The byte stored in the line control register selects one of three access modes: run, main configuration or extended configuration. The mode decides which physical register a shared offset reaches. The serial shifters and the FIFOs sit outside the block. The block passes transmit bytes out as push pulses and takes receive bytes in with a pop pulse. It also takes in the two line status flags.

Beyond plain storage, the block does four more things. It gates the enhanced control bits behind an enable bit in the feature register. It exposes a trigger-level register only inside a sub-mode. It holds a two-byte divisor that reaches the baud generator only when a run-mode register is written. It runs a fixed-length soft reset, and software polls a done flag to see when it has finished. The bus is a single-cycle synchronous request with 16-bit data. Read data is registered and is valid in the cycle after the request.

Top module: `uart_bank_regs`

## Requirements
- R1: The line control register sits at offset 3 in every mode and reads back its byte. The value 0xBF selects extended configuration mode. Any other value with bit 7 set selects main configuration mode. A value with bit 7 clear selects run mode. All registers reset to 0 except the run-mode register, which resets to 7.
- R2: In run mode, offset 0 is the data port and offset 1 is the interrupt enable register. In main configuration mode, offset 2 is the FIFO control register and offset 4 is the modem control register. In extended configuration mode, offset 0 is the divisor low byte, offset 1 is the divisor high byte and offset 2 is the feature register.
- R3: A read from an offset that the current mode does not map returns 0, and a write to it is ignored. Offsets 7 and 11 to 15 are never mapped. Changing the mode leaves every stored register unchanged.
- R4: While feature bit 4 is 0, a write to the interrupt enable register leaves its bits 7:4 unchanged, and a write to the modem control register leaves its bit 6 unchanged.
- R5: The trigger-level register sits at offset 6 in main configuration mode. It is mapped only while modem control bit 6 and feature bit 4 are both 1. `trig_sub_o` reports that condition.
- R6: `fifo_en_o` follows bit 0 of the FIFO control register.
- R7: A write with bit 1 set to the system config register (offset 9) starts a soft reset that lasts 4 cycles. While it runs, offset 9 reads 0x0002 and the status register (offset 10) reads 0. Afterwards, offset 9 reads 0 and offset 10 reads 1. Every register returns to its reset value, and bus writes made during the reset are ignored.
- R8: The run-mode register (offset 8, bits 2:0) is mapped in every mode. While it holds 7, `uart_off_o` is 1. A write whose bits 2:0 are 0 copies {high, low} divisor bytes to `divisor_o`.
- R9: The line status register (offset 5) reads `rx_avail_i` at bit 0 and `tx_empty_i` at bit 5, with all other bits 0. Writes to it have no effect.
- R10: In run mode, a write to offset 0 pulses `tx_push_o` in the same cycle, with `tx_byte_o` equal to write data bits 7:0. A read of offset 0 returns `rx_byte_i` and pulses `rx_pop_o`. In the other modes, offset 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read |
| rx_avail_i | input | 1 | Receive data available flag |
| tx_empty_i | input | 1 | Transmit FIFO empty flag |
| rx_byte_i | input | 8 | Head byte of receive FIFO |
| rx_pop_o | output | 1 | Receive FIFO pop pulse |
| tx_push_o | output | 1 | Transmit FIFO push pulse |
| tx_byte_o | output | 8 | Byte to push |
| divisor_o | output | 16 | Active baud divisor (16x oversampling) |
| uart_off_o | output | 1 | Port held disabled |
| fifo_en_o | output | 1 | FIFOs enabled |
| trig_sub_o | output | 1 | Trigger-level sub-mode active |

## Verification
Two functions can land in the same cycle. One is the soft-reset sequencer clearing the registers. The other is a bus write that targets one of those registers. The bench starts a soft reset and then, on back-to-back cycles, polls the status flag and issues a line control write while the reset is still running. The poll must read 0 through exactly four cycles and 1 on the fifth. The line control register must read 0 afterwards, which proves that the reset won over the write. A second overlap is a mode-changing write followed at once by a banked access. The randomized phase provokes this repeatedly and judges each read against a bench model that decodes the mode from the last line control value.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_CFG_MAIN = 2'd1,
    MODE_CFG_EXT = 2'd2
  } mode_e;

  localparam logic [3:0] OFS_DATA = 4'd0;
  localparam logic [3:0] OFS_IEN  = 4'd1;
  localparam logic [3:0] OFS_FCTL = 4'd2;
  localparam logic [3:0] OFS_LINE = 4'd3;
  localparam logic [3:0] OFS_MCTL = 4'd4;
  localparam logic [3:0] OFS_STAT = 4'd5;
  localparam logic [3:0] OFS_TRIG = 4'd6;
  localparam logic [3:0] OFS_RUNM = 4'd8;
  localparam logic [3:0] OFS_SCFG = 4'd9;
  localparam logic [3:0] OFS_SSTS = 4'd10;

  localparam logic [7:0] LINE_EXT_KEY = 8'hBF;
  localparam int LINE_CFG_BIT  = 7;
  localparam int FEAT_ENH_BIT  = 4;
  localparam int MCTL_SUB_BIT  = 6;
  localparam int FCTL_EN_BIT   = 0;
  localparam int SCFG_SRST_BIT = 1;
  localparam int STAT_RX_BIT   = 0;
  localparam int STAT_TX_BIT   = 5;
  localparam int RUNM_W        = 3;
  localparam logic [RUNM_W-1:0] RUNM_OFF = 3'd7;
endpackage

// File: rtl/uart_mode_dec.sv
module uart_mode_dec
  import uart_bank_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic [REG_W-1:0] line_i,
  output mode_e            mode_o
);
  always_comb begin
    if (line_i == REG_W'(LINE_EXT_KEY)) mode_o = MODE_CFG_EXT;
    else if (line_i[LINE_CFG_BIT])      mode_o = MODE_CFG_MAIN;
    else                                mode_o = MODE_RUN;
  end
endmodule

// File: rtl/uart_srst_seq.sv
module uart_srst_seq #(
  parameter int RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(RST_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (start_i && cnt_q == '0)    cnt_q <= CNT_W'(RST_CYC);
    else if (cnt_q != '0)               cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/uart_div_latch.sv
module uart_div_latch
  import uart_bank_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic                runm_we_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    lo_o,
  output logic [REG_W-1:0]    hi_o,
  output logic [RUNM_W-1:0]   runm_o,
  output logic [2*REG_W-1:0]  div_o,
  output logic                off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o   <= '0;
      hi_o   <= '0;
      runm_o <= RUNM_OFF;
      div_o  <= '0;
    end else if (clr_i) begin
      lo_o   <= '0;
      hi_o   <= '0;
      runm_o <= RUNM_OFF;
      div_o  <= '0;
    end else begin
      if (lo_we_i) lo_o <= wdata_i;
      if (hi_we_i) hi_o <= wdata_i;
      if (runm_we_i) begin
        runm_o <= wdata_i[RUNM_W-1:0];
        // return to normal operation reloads the baud divisor
        if (wdata_i[RUNM_W-1:0] == '0) div_o <= {hi_o, lo_o};
      end
    end
  end

  assign off_o = (runm_o == RUNM_OFF);
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int REG_W   = 8,
  parameter int RST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_avail_i,
  input  logic              tx_empty_i,
  input  logic [REG_W-1:0]  rx_byte_i,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [REG_W-1:0]  tx_byte_o,
  output logic [2*REG_W-1:0] divisor_o,
  output logic              uart_off_o,
  output logic              fifo_en_o,
  output logic              trig_sub_o
);
  localparam logic [REG_W-1:0] IEN_LO_MASK  = REG_W'(8'h0F);
  localparam logic [REG_W-1:0] MCTL_SUB_MSK = REG_W'(1) << MCTL_SUB_BIT;

  mode_e mode;
  logic  srst_busy, srst_start;
  logic  wr, rd;
  logic [REG_W-1:0] line_q, ien_q, feat_q, mctl_q, fctl_q, trig_q;
  logic [REG_W-1:0] div_lo, div_hi;
  logic [RUNM_W-1:0] runm;
  logic [REG_W-1:0] rd_val;
  logic line_we, ien_we, lo_we, hi_we, feat_we, fctl_we, mctl_we, trig_we, runm_we;
  logic enh;
  logic unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:REG_W];

  uart_mode_dec #(.REG_W(REG_W)) u_mode (
    .line_i (line_q),
    .mode_o (mode)
  );

  uart_srst_seq #(.RST_CYC(RST_CYC)) u_srst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srst_start),
    .busy_o  (srst_busy)
  );

  assign enh        = feat_q[FEAT_ENH_BIT];
  assign trig_sub_o = mctl_q[MCTL_SUB_BIT] & enh;
  assign fifo_en_o  = fctl_q[FCTL_EN_BIT];

  // writes are dropped while the soft reset runs
  assign wr = req_i & we_i & ~srst_busy;
  assign rd = req_i & ~we_i;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [3:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign srst_start = req_i & we_i & at(addr_i, OFS_SCFG) & wdata_i[SCFG_SRST_BIT] & ~srst_busy;
  assign line_we = wr & at(addr_i, OFS_LINE);
  assign ien_we  = wr & at(addr_i, OFS_IEN)  & (mode == MODE_RUN);
  assign lo_we   = wr & at(addr_i, OFS_DATA) & (mode == MODE_CFG_EXT);
  assign hi_we   = wr & at(addr_i, OFS_IEN)  & (mode == MODE_CFG_EXT);
  assign feat_we = wr & at(addr_i, OFS_FCTL) & (mode == MODE_CFG_EXT);
  assign fctl_we = wr & at(addr_i, OFS_FCTL) & (mode == MODE_CFG_MAIN);
  assign mctl_we = wr & at(addr_i, OFS_MCTL) & (mode == MODE_CFG_MAIN);
  assign trig_we = wr & at(addr_i, OFS_TRIG) & (mode == MODE_CFG_MAIN) & trig_sub_o;
  assign runm_we = wr & at(addr_i, OFS_RUNM);

  assign tx_push_o = wr & at(addr_i, OFS_DATA) & (mode == MODE_RUN);
  assign tx_byte_o = wdata_i[REG_W-1:0];
  assign rx_pop_o  = rd & at(addr_i, OFS_DATA) & (mode == MODE_RUN);

  uart_div_latch #(.REG_W(REG_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (srst_busy),
    .lo_we_i   (lo_we),
    .hi_we_i   (hi_we),
    .runm_we_i (runm_we),
    .wdata_i   (wdata_i[REG_W-1:0]),
    .lo_o      (div_lo),
    .hi_o      (div_hi),
    .runm_o    (runm),
    .div_o     (divisor_o),
    .off_o     (uart_off_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      ien_q  <= '0;
      feat_q <= '0;
      mctl_q <= '0;
      fctl_q <= '0;
      trig_q <= '0;
    end else if (srst_busy) begin
      line_q <= '0;
      ien_q  <= '0;
      feat_q <= '0;
      mctl_q <= '0;
      fctl_q <= '0;
      trig_q <= '0;
    end else begin
      if (line_we) line_q <= wdata_i[REG_W-1:0];
      if (ien_we)
        ien_q <= enh ? wdata_i[REG_W-1:0]
                     : (ien_q & ~IEN_LO_MASK) | (wdata_i[REG_W-1:0] & IEN_LO_MASK);
      if (feat_we) feat_q <= wdata_i[REG_W-1:0];
      if (fctl_we) fctl_q <= wdata_i[REG_W-1:0];
      if (mctl_we)
        mctl_q <= enh ? wdata_i[REG_W-1:0]
                      : (mctl_q & MCTL_SUB_MSK) | (wdata_i[REG_W-1:0] & ~MCTL_SUB_MSK);
      if (trig_we) trig_q <= wdata_i[REG_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      ADDR_W'(OFS_DATA): begin
        if (mode == MODE_RUN)          rd_val = rx_byte_i;
        else if (mode == MODE_CFG_EXT) rd_val = div_lo;
      end
      ADDR_W'(OFS_IEN): begin
        if (mode == MODE_RUN)          rd_val = ien_q;
        else if (mode == MODE_CFG_EXT) rd_val = div_hi;
      end
      ADDR_W'(OFS_FCTL): begin
        if (mode == MODE_CFG_MAIN)     rd_val = fctl_q;
        else if (mode == MODE_CFG_EXT) rd_val = feat_q;
      end
      ADDR_W'(OFS_LINE): rd_val = line_q;
      ADDR_W'(OFS_MCTL): if (mode == MODE_CFG_MAIN) rd_val = mctl_q;
      ADDR_W'(OFS_STAT): begin
        rd_val[STAT_RX_BIT] = rx_avail_i;
        rd_val[STAT_TX_BIT] = tx_empty_i;
      end
      ADDR_W'(OFS_TRIG): if (mode == MODE_CFG_MAIN && trig_sub_o) rd_val = trig_q;
      ADDR_W'(OFS_RUNM): rd_val = REG_W'(runm);
      ADDR_W'(OFS_SCFG): rd_val[SCFG_SRST_BIT] = srst_busy;
      ADDR_W'(OFS_SSTS): rd_val[0] = ~srst_busy;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= DATA_W'(rd_val);
    else          rdata_o <= '0;
  end
endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rx_avail_i,
  input logic              tx_empty_i,
  input logic              tx_push_o,
  input logic [2*REG_W-1:0] divisor_o,
  input logic              uart_off_o,
  input logic              srst_busy,
  input mode_e             mode,
  input logic [REG_W-1:0]  feat_q,
  input logic [REG_W-1:0]  mctl_q,
  input logic [REG_W-1:0]  ien_q,
  input logic [REG_W-1:0]  div_lo,
  input logic [REG_W-1:0]  div_hi
);
  assert_srst_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFS_SCFG) && wdata_i[SCFG_SRST_BIT] && !srst_busy)
    |=> srst_busy);

  assert_srst_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_busy |=> (feat_q == '0 && div_lo == '0 && div_hi == '0 && uart_off_o));

  assert_ien_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!feat_q[FEAT_ENH_BIT] && !srst_busy) |=> $stable(ien_q[REG_W-1:4]));

  assert_mctl_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!feat_q[FEAT_ENH_BIT] && !srst_busy) |=> $stable(mctl_q[MCTL_SUB_BIT]));

  assert_stat_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFS_STAT))
    |=> rdata_o == {10'b0, $past(tx_empty_i), 4'b0, $past(rx_avail_i)});

  assert_push_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> (mode == MODE_RUN && we_i && addr_i == ADDR_W'(OFS_DATA)));

  assert_div_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFS_RUNM) && wdata_i[RUNM_W-1:0] == '0 && !srst_busy)
    |=> (divisor_o == {$past(div_hi), $past(div_lo)} && !uart_off_o));

  assert_unmapped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == ADDR_W'(4'd7) || addr_i >= ADDR_W'(4'd11)))
    |=> rdata_o == '0);

  assert_mode_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFS_LINE) && !srst_busy)
    |=> ($stable(div_lo) && $stable(feat_q) && $stable(mctl_q)));
endmodule

bind uart_bank_regs uart_bank_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .rx_avail_i (rx_avail_i),
  .tx_empty_i (tx_empty_i),
  .tx_push_o  (tx_push_o),
  .divisor_o  (divisor_o),
  .uart_off_o (uart_off_o),
  .srst_busy  (srst_busy),
  .mode       (mode),
  .feat_q     (feat_q),
  .mctl_q     (mctl_q),
  .ien_q      (ien_q),
  .div_lo     (div_lo),
  .div_hi     (div_hi)
);

// File: tb/uart_bank_regs_bench.sv
module uart_bank_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rx_avail = 1'b0, tx_empty = 1'b1;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_pop, tx_push, uart_off, fifo_en, trig_sub;
  logic [7:0]  tx_byte;
  logic [15:0] divisor;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_bank_regs u_uart_bank_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_avail_i(rx_avail), .tx_empty_i(tx_empty),
    .rx_byte_i(rx_byte), .rx_pop_o(rx_pop), .tx_push_o(tx_push), .tx_byte_o(tx_byte),
    .divisor_o(divisor), .uart_off_o(uart_off), .fifo_en_o(fifo_en), .trig_sub_o(trig_sub)
  );

  // bench model
  logic [7:0] m_line, m_ien, m_feat, m_mctl, m_fctl, m_trig, m_lo, m_hi;
  logic [2:0] m_runm;
  logic [15:0] m_div;

  task automatic model_reset();
    m_line = 0; m_ien = 0; m_feat = 0; m_mctl = 0; m_fctl = 0; m_trig = 0;
    m_lo = 0; m_hi = 0; m_runm = 3'd7; m_div = 0;
  endtask

  function automatic int m_mode();
    if (m_line == 8'hBF) return 2;
    if (m_line[7])       return 1;
    return 0;
  endfunction

  function automatic logic m_sub();
    return m_mctl[6] & m_feat[4];
  endfunction

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return (m_mode() == 0) ? {8'h0, rx_byte} : (m_mode() == 2) ? {8'h0, m_lo} : 16'h0;
      4'd1: return (m_mode() == 0) ? {8'h0, m_ien} : (m_mode() == 2) ? {8'h0, m_hi} : 16'h0;
      4'd2: return (m_mode() == 1) ? {8'h0, m_fctl} : (m_mode() == 2) ? {8'h0, m_feat} : 16'h0;
      4'd3: return {8'h0, m_line};
      4'd4: return (m_mode() == 1) ? {8'h0, m_mctl} : 16'h0;
      4'd5: return {10'h0, tx_empty, 4'h0, rx_avail};
      4'd6: return (m_mode() == 1 && m_sub()) ? {8'h0, m_trig} : 16'h0;
      4'd8: return {13'h0, m_runm};
      4'd10: return 16'h1;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_write(input logic [3:0] a, input logic [15:0] d);
    int md = m_mode();
    case (a)
      4'd0: if (md == 2) m_lo = d[7:0];
      4'd1: if (md == 0) m_ien = m_feat[4] ? d[7:0] : {m_ien[7:4], d[3:0]};
            else if (md == 2) m_hi = d[7:0];
      4'd2: if (md == 1) m_fctl = d[7:0]; else if (md == 2) m_feat = d[7:0];
      4'd3: m_line = d[7:0];
      4'd4: if (md == 1) m_mctl = m_feat[4] ? d[7:0] : {d[7], m_mctl[6], d[5:0]};
      4'd6: if (md == 1 && m_sub()) m_trig = d[7:0];
      4'd8: begin m_runm = d[2:0]; if (d[2:0] == 3'd0) m_div = {m_hi, m_lo}; end
      default: ;
    endcase
  endtask

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    logic exp_push;
    exp_push = (m_mode() == 0) && (a == 4'd0);
    req = 1; we = 1; addr = a; wdata = d;
    #1;
    chk("R10 push", {15'h0, tx_push}, {15'h0, exp_push});
    if (exp_push) chk("R10 byte", {8'h0, tx_byte}, {8'h0, d[7:0]});
    @(negedge clk);
    req = 0; we = 0;
    model_write(a, d);
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] v);
    req = 1; we = 0; addr = a;
    #1;
    chk("R10 pop", {15'h0, rx_pop}, {15'h0, (m_mode() == 0) && (a == 4'd0)});
    @(negedge clk);
    req = 0;
    v = rdata;
  endtask

  task automatic rd_chk(input string r, input logic [3:0] a);
    logic [15:0] e, v;
    e = exp_read(a);
    bus_rd(a, v);
    chk(r, v, e);
  endtask

  task automatic out_chk();
    chk("R8 divisor", divisor, m_div);
    chk("R8 off", {15'h0, uart_off}, {15'h0, m_runm == 3'd7});
    chk("R6 fifo_en", {15'h0, fifo_en}, {15'h0, m_fctl[0]});
    chk("R5 trig_sub", {15'h0, trig_sub}, {15'h0, m_sub()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    model_reset();
    #23 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 reset line", 4'd3);
    rd_chk("R1 reset runm", 4'd8);
    rd_chk("R7 reset status", 4'd10);
    out_chk();

    // R1/R2 extended mode divisor bytes
    bus_wr(4'd3, 16'h00BF);
    bus_wr(4'd0, 16'h0034);
    bus_wr(4'd1, 16'h0012);
    rd_chk("R2 div lo", 4'd0);
    rd_chk("R2 div hi", 4'd1);
    // R3 mode change keeps contents
    bus_wr(4'd3, 16'h0080);
    rd_chk("R3 unmapped in main", 4'd0);
    bus_wr(4'd0, 16'h00EE);
    bus_wr(4'd3, 16'h00BF);
    rd_chk("R3 kept lo", 4'd0);
    // R4 gate on sub-mode bit
    bus_wr(4'd3, 16'h0080);
    bus_wr(4'd4, 16'h0041);
    rd_chk("R4 mctl gated", 4'd4);
    bus_wr(4'd6, 16'h0055);
    rd_chk("R5 trig hidden", 4'd6);
    bus_wr(4'd3, 16'h00BF);
    bus_wr(4'd2, 16'h0010);
    bus_wr(4'd3, 16'h0080);
    bus_wr(4'd4, 16'h0040);
    rd_chk("R4 mctl open", 4'd4);
    bus_wr(4'd6, 16'h0055);
    rd_chk("R5 trig visible", 4'd6);
    bus_wr(4'd2, 16'h0001);
    out_chk();
    // R8 load divisor
    bus_wr(4'd8, 16'h0000);
    out_chk();
    // R9/R10 run mode
    bus_wr(4'd3, 16'h0003);
    rx_avail = 1; tx_empty = 0; rx_byte = 8'hA5;
    rd_chk("R9 status", 4'd5);
    rd_chk("R10 rx data", 4'd0);
    bus_wr(4'd0, 16'h005A);
    bus_wr(4'd1, 16'h00FF);
    rd_chk("R4 ien open", 4'd1);
    rd_chk("R3 never mapped 7", 4'd7);
    rd_chk("R3 never mapped 12", 4'd12);

    // R7 soft reset collides with a bus write
    bus_wr(4'd9, 16'h0002);
    model_reset();
    bus_rd(4'd10, v); chk("R7 busy status c1", v, 16'h0);
    bus_rd(4'd9, v);  chk("R7 busy cfg c2", v, 16'h2);
    req = 1; we = 1; addr = 4'd3; wdata = 16'h0080;
    @(negedge clk); req = 0; we = 0;
    bus_rd(4'd10, v); chk("R7 busy status c4", v, 16'h0);
    bus_rd(4'd10, v); chk("R7 done status", v, 16'h1);
    bus_rd(4'd9, v);  chk("R7 cfg cleared", v, 16'h0);
    rd_chk("R7 line cleared", 4'd3);
    rd_chk("R7 runm reset", 4'd8);
    out_chk();

    // randomized phase
    for (int i = 0; i < 800; i++) begin
      int sel;
      logic [3:0] a;
      logic [15:0] d;
      sel = int'($urandom_range(0, 9));
      rx_avail = 1'($urandom); tx_empty = 1'($urandom); rx_byte = 8'($urandom);
      a = 4'($urandom);
      if (a == 4'd9) a = 4'd8;
      d = 16'($urandom);
      if (sel < 2) begin
        case ($urandom_range(0, 4))
          0: d = 16'h00BF;
          1: d = 16'h0080;
          2: d = 16'h0003;
          3: d = 16'h0000;
          default: ;
        endcase
        bus_wr(4'd3, d);
      end else if (sel < 6) begin
        bus_wr(a, d);
      end else begin
        rd_chk("R2 random read", a);
      end
      if (i % 8 == 0) out_chk();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule